// File: doc/BRIEF.md
# Seconds/minutes watchdog timer

A countdown watchdog with a small byte-wide register port. Software programs a configuration byte and a reload count split over two byte registers. The count is made live in one step when its low byte is written: the high byte waits in a holding register until then, so the counter never holds half of an old value and half of a new one. A nonzero count starts the timer, or restarts it from the new value, which makes every write of the count a keep-alive. A count of zero stops it.

The timer steps on a one-cycle seconds strobe. A unit bit in the configuration chooses between one step per strobe and one step per sixty strobes. In the second case an internal divide-by-sixty prescaler makes the steps, and any count write clears it. When the count runs out, the block sets a sticky timeout flag. If enabled, it also drives a reset pulse for a fixed number of clock cycles, and it can present the timeout flag on a level output.

Top module: `wdog_timer`

## Requirements
- R1: After reset the configuration register (index 0x72) reads 0x80, the control register (index 0x71) reads 0x00, both count bytes read 0x00, and `rst_out` and `tmo_out` are low.
- R2: The configuration register stores and reads back all 8 bits. Bit 7 = 1 selects the seconds unit, bit 6 enables the reset pulse, bit 5 enables `tmo_out`, and bits 4:0 are held for software.
- R3: A write to index 0x74 only fills a holding register. A write to index 0x73 loads the counter with {held byte, written byte}. Reads of 0x73 and 0x74 return the live count's low and high bytes.
- R4: Loading a count of zero stops the timer: `sec_tick` pulses then change nothing, and no timeout follows.
- R5: In seconds mode, a count of N decreases by one on each `sec_tick` and reaches zero on the N-th pulse. The timeout flag is set on that same clock edge.
- R6: In minutes mode (bit 7 = 0), the count decreases once every 60 `sec_tick` pulses. A count write clears the partial progress toward the next step.
- R7: Writing a new count while the timer runs reloads it, and the countdown restarts from the new value.
- R8: The timeout flag is control bit 0. It stays set until software writes a 1 to bit 0 of index 0x71. Writing a 0 there leaves it set.
- R9: On timeout with configuration bit 6 set, `rst_out` is high for exactly RST_CYC clock cycles, starting on the expiry edge. With bit 6 clear it stays low.
- R10: `tmo_out` is high exactly while the timeout flag is set and configuration bit 5 is set.
- R11: After a timeout the counter stays at zero, and further `sec_tick` pulses cause no second timeout or reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register index for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| rst_out | output | 1 | Reset pulse on timeout |
| tmo_out | output | 1 | Timeout flag, gated by configuration bit 5 |

## Verification
A register write takes effect on the clock edge during which `wr_en` is high. It is visible on `rdata` at the next falling edge. A count step lands on the edge that samples `sec_tick`, and the timeout flag and `rst_out` rise on that same edge as the final step. `rst_out` then falls RST_CYC edges later. The bench drives every input on a falling edge and reads every output on a later falling edge, after the edge the input affected. Each check is therefore made in the first cycle its result is due, and `rst_out` is measured by counting the falling edges while it stays high.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam logic [7:0] IDX_CTRL = 8'h71;
    localparam logic [7:0] IDX_CFG  = 8'h72;
    localparam logic [7:0] IDX_CLO  = 8'h73;
    localparam logic [7:0] IDX_CHI  = 8'h74;
    localparam logic [7:0] CFG_RESET = 8'h80;

    typedef struct packed {
        logic       unit_sec;
        logic       rst_en;
        logic       tmo_en;
        logic       pwr_gate;
        logic [3:0] irq_sel;
    } cfg_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs #(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [7:0]          addr,
    input  logic [7:0]          wdata,
    input  logic [CNT_W-1:0]    cnt,
    input  logic                status,
    output wdog_pkg::cfg_t      cfg,
    output logic                load_stb,
    output logic [CNT_W-1:0]    load_val,
    output logic                clr_stb,
    output logic [7:0]          rdata
);
    import wdog_pkg::*;

    localparam int HOLD_W = (CNT_W > 8) ? CNT_W - 8 : 1;

    typedef struct packed {
        cfg_t              cfg;
        logic [HOLD_W-1:0] hold;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic [15:0] cnt16;

    assign load_stb = wr_en && (addr == IDX_CLO);
    assign clr_stb  = wr_en && (addr == IDX_CTRL) && wdata[0];
    assign cfg      = st_q.cfg;
    assign cnt16    = 16'(cnt);

    generate
        if (CNT_W > 8) begin : g_wide
            assign load_val = {st_q.hold, wdata};
        end else begin : g_narrow
            assign load_val = wdata[CNT_W-1:0];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (addr == IDX_CFG) st_d.cfg  = cfg_t'(wdata);
            if (addr == IDX_CHI) st_d.hold = wdata[HOLD_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg  <= cfg_t'(CFG_RESET);
            st_q.hold <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (addr)
            IDX_CTRL: rdata = {7'b0, status};
            IDX_CFG:  rdata = st_q.cfg;
            IDX_CLO:  rdata = cnt16[7:0];
            IDX_CHI:  rdata = cnt16[15:8];
            default:  rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int DIV = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic unit_sec,
    input  logic clear,
    input  logic run,
    output logic step
);
    localparam int PW = $clog2(DIV);

    logic [PW-1:0] div_d, div_q;
    logic          wrap;

    assign wrap = (div_q == PW'(DIV - 1));
    assign step = run && sec_tick && (unit_sec || wrap);

    always_comb begin
        div_d = div_q;
        if (clear || !run || unit_sec) begin
            div_d = '0;
        end else if (sec_tick) begin
            div_d = wrap ? '0 : div_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W   = 16,
    parameter int RST_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  logic             clr_stb,
    input  logic             rst_en,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             status,
    output logic             rst_out
);
    localparam int PLS_W = $clog2(RST_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             status;
        logic [PLS_W-1:0] pulse;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    expire;

    assign cnt     = st_q.cnt;
    assign running = (st_q.cnt != '0);
    assign status  = st_q.status;
    assign rst_out = (st_q.pulse != '0);

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (load_stb) begin
            st_d.cnt = load_val;
        end else if (running && step) begin
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.cnt = '0;
                expire   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (st_q.pulse != '0) st_d.pulse = st_q.pulse - 1'b1;
        if (clr_stb)          st_d.status = 1'b0;
        if (expire) begin
            st_d.status = 1'b1;
            if (rst_en) st_d.pulse = PLS_W'(RST_CYC);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
    parameter int CNT_W   = 16,
    parameter int DIV     = 60,
    parameter int RST_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       rst_out,
    output logic       tmo_out
);
    wdog_pkg::cfg_t   cfg_w;
    logic             load_w;
    logic [CNT_W-1:0] load_val_w;
    logic             clr_w;
    logic [CNT_W-1:0] cnt_w;
    logic             running_w;
    logic             status_w;
    logic             step_w;

    wdog_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cnt(cnt_w), .status(status_w), .cfg(cfg_w), .load_stb(load_w),
        .load_val(load_val_w), .clr_stb(clr_w), .rdata(rdata)
    );

    wdog_prescale #(.DIV(DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .unit_sec(cfg_w.unit_sec),
        .clear(load_w), .run(running_w), .step(step_w)
    );

    wdog_counter #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_stb(load_w), .load_val(load_val_w),
        .step(step_w), .clr_stb(clr_w), .rst_en(cfg_w.rst_en), .cnt(cnt_w),
        .running(running_w), .status(status_w), .rst_out(rst_out)
    );

    assign tmo_out = status_w && cfg_w.tmo_en;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
    parameter int CNT_W   = 16,
    parameter int RST_CYC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [7:0]       addr,
    input logic [CNT_W-1:0] cnt,
    input logic             status,
    input logic             rst_out
);
    logic        lo_wr;
    logic [15:0] hi_len;

    assign lo_wr = wr_en && (addr == wdog_pkg::IDX_CLO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hi_len <= '0;
        else if (rst_out) hi_len <= hi_len + 1'b1;
        else              hi_len <= '0;
    end

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_wr |=> (cnt == $past(cnt)) || (cnt == $past(cnt) - 1'b1)); // R5
    AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) && !lo_wr |=> (cnt == '0)); // R4
    AST_EXPIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> (cnt == '0)); // R5
    AST_RST_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out) |-> status); // R9
    AST_RST_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        hi_len <= 16'(RST_CYC)); // R9
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .cnt(cnt_w), .status(status_w), .rst_out(rst_out)
);

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int RST_CYC    = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       rst_out;
    logic       tmo_out;

    int total = 0;
    int bad = 0;

    wdog_timer #(.CNT_W(16), .DIV(60), .RST_CYC(RST_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rst_out(rst_out),
        .tmo_out(tmo_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int exp_pulse(input logic [7:0] cfg);
        return cfg[6] ? RST_CYC : 0;
    endfunction

    function automatic logic exp_tmo(input logic flag, input logic [7:0] cfg);
        return flag && cfg[5];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic load(input logic [15:0] v);
        wr(8'h74, v[15:8]);
        wr(8'h73, v[7:0]);
    endtask

    task automatic get_cnt(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(8'h73, lo);
        rd(8'h74, hi);
        v = {hi, lo};
    endtask

    task automatic get_flag(output logic f);
        logic [7:0] c;
        rd(8'h71, c);
        f = c[0];
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sec_tick = 1'b1;
            @(negedge clk);
            sec_tick = 1'b0;
        end
    endtask

    task automatic pulse_len(output int n);
        n = 0;
        while (rst_out && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] c;
        logic        f;
        int          n;
        int          seed_set;

        seed_set = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h72, d); chk("R1 cfg", d, 8'h80);
        rd(8'h71, d); chk("R1 ctrl", d, 8'h00);
        get_cnt(c);   chk("R1 count", c, 0);
        chk("R1 rst_out", rst_out, 0);
        chk("R1 tmo_out", tmo_out, 0);

        // R2 configuration read-back
        wr(8'h72, 8'h9a); rd(8'h72, d); chk("R2 cfg 9a", d, 8'h9a);
        wr(8'h72, 8'hc5); rd(8'h72, d); chk("R2 cfg c5", d, 8'hc5);

        // R3 high byte is held, low byte commits
        wr(8'h74, 8'h12); get_cnt(c); chk("R3 hi only", c, 0);
        wr(8'h73, 8'h34); get_cnt(c); chk("R3 commit", c, 16'h1234);

        // R4 zero stops the timer
        load(16'd3); load(16'd0); ticks(10);
        get_cnt(c); chk("R4 count", c, 0);
        get_flag(f); chk("R4 flag", f, 0);
        chk("R4 rst_out", rst_out, 0);

        // R7 keep-alive reload, seconds mode
        wr(8'h72, 8'h80);
        load(16'd5); ticks(3); get_cnt(c); chk("R5 countdown", c, 2);
        load(16'd5); ticks(4); get_cnt(c); chk("R7 reload", c, 1);
        get_flag(f); chk("R7 no flag", f, 0);
        load(16'd0);

        // R6 minutes mode with prescaler clear on reload
        wr(8'h72, 8'h40);
        load(16'd2); ticks(59); get_cnt(c); chk("R6 before step", c, 2);
        ticks(1); get_cnt(c); chk("R6 first step", c, 1);
        ticks(30); load(16'd1); ticks(59);
        get_cnt(c); chk("R6 prescaler cleared", c, 1);
        get_flag(f); chk("R6 no flag yet", f, 0);
        ticks(1); get_flag(f); chk("R6 expiry", f, 1);
        chk("R9 pulse start", rst_out, 1);
        pulse_len(n); chk("R9 pulse length", n, RST_CYC);

        // R8 sticky flag, write-1-to-clear
        wr(8'h71, 8'h00); get_flag(f); chk("R8 write 0 keeps", f, 1);
        // R10 timeout output gating
        wr(8'h72, 8'hA0); chk("R10 tmo on", tmo_out, 1);
        wr(8'h71, 8'h01); get_flag(f); chk("R8 write 1 clears", f, 0);
        chk("R10 tmo off", tmo_out, 0);

        // R11 nothing after expiry; R9 no pulse with bit 6 clear
        wr(8'h72, 8'h80);
        load(16'd1); ticks(1);
        get_flag(f); chk("R5 one-tick expiry", f, 1);
        chk("R9 no pulse", rst_out, 0);
        wr(8'h71, 8'h01); ticks(5);
        get_cnt(c); chk("R11 count stays", c, 0);
        get_flag(f); chk("R11 no second timeout", f, 0);

        // Random seconds-mode runs
        for (int it = 0; it < 30; it++) begin
            logic [7:0] cfg;
            int         len;
            cfg = {1'b1, 7'($urandom)};
            len = 1 + int'($urandom % 12);
            wr(8'h72, cfg);
            wr(8'h71, 8'h01);
            load(16'(len));
            ticks(len - 1);
            get_cnt(c);  chk("R5 random one left", c, 1);
            get_flag(f); chk("R5 random no flag", f, 0);
            ticks(1);
            get_flag(f); chk("R5 random flag", f, 1);
            chk("R10 random tmo", tmo_out, exp_tmo(1'b1, cfg));
            pulse_len(n); chk("R9 random pulse", n, exp_pulse(cfg));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule